// File: doc/BRIEF.md
# Exhaustive Key-Search Driver Stage

This block is the control stage that sits beside one cryptographic test engine on each chip of a large array that searches a key space in parallel. It holds the candidate key under test together with a one-bit "found" status in a single 65-bit register. Every chip's register is linked into one chain through a few-pin serial bus: a host shifts starting keys into the whole chain once, lets every chip search on its own, and later shifts the chain back out to learn which chip found a match and with what key.

During search the key does not count in binary. Instead it is multiplied by x modulo the primitive polynomial x^64 + x^4 + x^3 + x + 1 on each step (a Galois LFSR), which costs a shift and three XOR gates instead of a 64-bit carry chain. That sequence covers every nonzero key but never reaches zero, so a zero key present at the start of a search is tested in the first cycle and then replaced by the seed value 1. The key is presented to the engine as two 32-bit halves, and the engine answers with a single match bit. On a match the status bit sets and the key freezes so that it can be read out serially.

The serial chain is bit-serial with `shift_en` as its only qualifier. It has no back-pressure: every chip in the chain shifts on the same clock edge.

Top module: `keysrch_driver`

## Requirements
- R1: While `rst_n` is low at a clock edge, the key and the status bit clear to zero on that edge, so `key_hi`, `key_lo` and `ser_out` read 0 afterwards.
- R2: While `shift_en` is high, the 65-bit register (status at bit 64, key bits 63..0 below it) shifts one place toward bit 64 per clock, `ser_in` entering at bit 0, and `ser_out` always shows bit 64. This holds whatever `run_en` and `hit` are.
- R3: Shifting a 65-bit word in over 65 clocks (first bit sent ends in bit 64) and then shifting 65 clocks out returns the same bits in the same order on `ser_out`.
- R4: With `run_en` high, `shift_en` low, the status bit clear, `hit` low and a nonzero key K, the next key is (K shifted left by one, bit 63 dropped) XOR 64'h1B when K[63] was 1, else the shifted value alone.
- R5: With the same stepping conditions and an all-zero key, the next key is 1.
- R6: With `run_en` high, `shift_en` low, the status bit clear and `hit` high, the status bit sets and the key keeps its value; this includes the all-zero key.
- R7: Once the status bit is set and `shift_en` is low, the key and the status bit stay unchanged, whatever `run_en` and `hit` do.
- R8: With `run_en` and `shift_en` both low, the key and status bit hold, and `hit` has no effect.
- R9: `key_hi` always shows key bits 63..32 and `key_lo` key bits 31..0 of the current register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Serial chain data from the previous chip |
| ser_out | output | 1 | Serial chain data to the next chip (register bit 64) |
| shift_en | input | 1 | Shift the chain one bit per clock |
| run_en | input | 1 | Allow the key to step |
| key_hi | output | 32 | Upper half of the current key, to the engine |
| key_lo | output | 32 | Lower half of the current key, to the engine |
| hit | input | 1 | Match result from the engine for the current key |

## Verification
On every cycle the assertions check the reset clearing, the bit movement through the chain while shifting, that the key freezes and the status sets on a hit, that a set status holds everything, that an idle cycle changes nothing, and that a zero key steps to 1 while a nonzero key steps to a nonzero key. Only the bench's scenarios can show that the stepped values follow the exact polynomial sequence over more than a thousand steps, that a full 65-bit word survives a serial round trip in order, and that a planted key is found and then read back out over the chain with its status bit in front.

// File: rtl/ks_pkg.sv
`timescale 1ns/1ps
package ks_pkg;
  typedef enum logic [2:0] {
    MODE_HOLD  = 3'd0,
    MODE_SHIFT = 3'd1,
    MODE_SEED  = 3'd2,
    MODE_STEP  = 3'd3,
    MODE_LATCH = 3'd4
  } ks_mode_e;
endpackage

// File: rtl/ks_lfsr_step.sv
`timescale 1ns/1ps
// One Galois step: multiply the state by x modulo the feedback polynomial.
module ks_lfsr_step #(
  parameter int KEY_W = 64,
  parameter logic [KEY_W-1:0] TAPS = 64'h1B
) (
  input  logic [KEY_W-1:0] cur,
  output logic [KEY_W-1:0] nxt
);
  logic fb;
  assign fb = cur[KEY_W-1];

  for (genvar i = 0; i < KEY_W; i++) begin : g_bit
    if (i == 0) begin : g_low
      assign nxt[i] = fb & TAPS[i];
    end else begin : g_up
      assign nxt[i] = cur[i-1] ^ (fb & TAPS[i]);
    end
  end
endmodule

// File: rtl/ks_ctrl.sv
`timescale 1ns/1ps
// Decides what the register does this cycle; shifting outranks everything.
module ks_ctrl
  import ks_pkg::*;
(
  input  logic     shift_en,
  input  logic     run_en,
  input  logic     found,
  input  logic     hit,
  input  logic     key_zero,
  output ks_mode_e mode
);
  always_comb begin
    if (shift_en)             mode = MODE_SHIFT;
    else if (!run_en || found) mode = MODE_HOLD;
    else if (hit)             mode = MODE_LATCH;
    else if (key_zero)        mode = MODE_SEED;
    else                      mode = MODE_STEP;
  end
endmodule

// File: rtl/ks_chain.sv
`timescale 1ns/1ps
// The 65-bit status+key register with its serial path.
module ks_chain
  import ks_pkg::*;
#(
  parameter int KEY_W = 64,
  localparam int CH_W = KEY_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ks_mode_e         mode,
  input  logic             ser_in,
  input  logic [KEY_W-1:0] step_key,
  output logic [CH_W-1:0]  chain
);
  localparam logic [KEY_W-1:0] SEED = KEY_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      unique case (mode)
        MODE_SHIFT: chain <= {chain[CH_W-2:0], ser_in};
        MODE_LATCH: chain[CH_W-1] <= 1'b1;
        MODE_SEED:  chain[KEY_W-1:0] <= SEED;
        MODE_STEP:  chain[KEY_W-1:0] <= step_key;
        default:    chain <= chain;
      endcase
    end
  end
endmodule

// File: rtl/keysrch_driver.sv
`timescale 1ns/1ps
module keysrch_driver
  import ks_pkg::*;
#(
  parameter int KEY_W = 64,
  parameter logic [KEY_W-1:0] TAPS = 64'h1B,
  localparam int HALF_W = KEY_W / 2,
  localparam int CH_W = KEY_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic              shift_en,
  input  logic              run_en,
  output logic [HALF_W-1:0] key_hi,
  output logic [HALF_W-1:0] key_lo,
  input  logic              hit
);
  logic [CH_W-1:0]  chain;
  logic [KEY_W-1:0] key;
  logic [KEY_W-1:0] step_key;
  ks_mode_e         mode;

  assign key = chain[KEY_W-1:0];

  ks_lfsr_step #(.KEY_W(KEY_W), .TAPS(TAPS)) u_step (
    .cur (key),
    .nxt (step_key)
  );

  ks_ctrl u_ctrl (
    .shift_en (shift_en),
    .run_en   (run_en),
    .found    (chain[CH_W-1]),
    .hit      (hit),
    .key_zero (key == '0),
    .mode     (mode)
  );

  ks_chain #(.KEY_W(KEY_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .ser_in   (ser_in),
    .step_key (step_key),
    .chain    (chain)
  );

  assign ser_out = chain[CH_W-1];
  assign key_hi  = key[KEY_W-1:HALF_W];
  assign key_lo  = key[HALF_W-1:0];
endmodule

// File: rtl/keysrch_driver_chk.sv
`timescale 1ns/1ps
module keysrch_driver_chk #(
  parameter int HALF_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_in,
  input logic              ser_out,
  input logic              shift_en,
  input logic              run_en,
  input logic [HALF_W-1:0] key_hi,
  input logic [HALF_W-1:0] key_lo,
  input logic              hit
);
  logic run_ok;
  assign run_ok = run_en && !shift_en && !ser_out;

  p_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (ser_out == 1'b0 && key_hi == '0 && key_lo == '0));

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (ser_out == $past(key_hi[HALF_W-1]) &&
                  key_hi[0] == $past(key_lo[HALF_W-1]) &&
                  key_lo[0] == $past(ser_in)));

  p_step_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ok && !hit && {key_hi, key_lo} != '0) |=>
      ({key_hi, key_lo} != '0 && !ser_out));

  p_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ok && !hit && {key_hi, key_lo} == '0) |=>
      ({key_hi, key_lo} == {{(2*HALF_W-1){1'b0}}, 1'b1}));

  p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ok && hit) |=> (ser_out && $stable(key_hi) && $stable(key_lo)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out && !shift_en) |=> (ser_out && $stable(key_hi) && $stable(key_lo)));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !shift_en) |=>
      ($stable(ser_out) && $stable(key_hi) && $stable(key_lo)));
endmodule

bind keysrch_driver keysrch_driver_chk #(.HALF_W(HALF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_in   (ser_in),
  .ser_out  (ser_out),
  .shift_en (shift_en),
  .run_en   (run_en),
  .key_hi   (key_hi),
  .key_lo   (key_lo),
  .hit      (hit)
);

// File: tb/sim_keysrch_driver.sv
`timescale 1ns/1ps
module sim_keysrch_driver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_in = 1'b0;
  logic        ser_out;
  logic        shift_en = 1'b0;
  logic        run_en = 1'b0;
  logic [31:0] key_hi, key_lo;
  logic        hit;
  logic        match_en = 1'b0;
  logic [63:0] target = '0;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  // Engine stand-in: a comparator against a planted key.
  assign hit = match_en && ({key_hi, key_lo} == target);

  keysrch_driver u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(ser_out),
    .shift_en(shift_en), .run_en(run_en), .key_hi(key_hi), .key_lo(key_lo),
    .hit(hit)
  );

  function automatic logic [63:0] model_next(input logic [63:0] k);
    // multiply by x mod x^64 + x^4 + x^3 + x + 1
    logic [63:0] r;
    r = {k[62:0], 1'b0};
    if (k[63]) r = r ^ 64'h1B;
    return r;
  endfunction

  task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; shift_en = 1'b0; run_en = 1'b0; match_en = 1'b0; ser_in = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic shift_word(input logic [64:0] p);
    shift_en = 1'b1;
    for (int i = 0; i < 65; i++) begin
      ser_in = p[64-i];
      tick(1);
    end
    shift_en = 1'b0; ser_in = 1'b0;
  endtask

  task automatic read_word(output logic [64:0] got);
    shift_en = 1'b1; ser_in = 1'b0;
    for (int i = 0; i < 65; i++) begin
      got[64-i] = ser_out;
      tick(1);
    end
    shift_en = 1'b0;
  endtask

  task automatic t_reset();
    shift_word(65'h1_FFFF_0000_FFFF_0000);
    do_reset();
    chk("R1 state after reset", {ser_out, key_hi, key_lo}, 65'h0);
  endtask

  task automatic t_roundtrip();
    logic [64:0] p, got;
    p = 65'h1_F0E1_D2C3_B4A5_9687;
    do_reset();
    shift_word(p);
    chk("R2 status at bit 64", {64'h0, ser_out}, {64'h0, p[64]});
    chk("R9 key_hi half", {33'h0, key_hi}, {33'h0, p[63:32]});
    chk("R9 key_lo half", {33'h0, key_lo}, {33'h0, p[31:0]});
    read_word(got);
    chk("R3 serial round trip", got, p);
    // shift outranks run and hit
    shift_word(p);
    target = p[63:0]; match_en = 1'b1; run_en = 1'b1; shift_en = 1'b1; ser_in = 1'b1;
    tick(1);
    shift_en = 1'b0; run_en = 1'b0; match_en = 1'b0; ser_in = 1'b0;
    chk("R2 shift wins over run", {ser_out, key_hi, key_lo}, {p[63:0], 1'b1});
  endtask

  task automatic t_steps();
    logic [63:0] m;
    int errs;
    do_reset();
    run_en = 1'b1;
    tick(1);
    chk("R5 zero key seeds to 1", {ser_out, key_hi, key_lo}, 65'h1);
    m = 64'h1;
    errs = 0;
    for (int i = 0; i < 1200; i++) begin
      m = model_next(m);
      tick(1);
      chk("R4 lfsr step", {ser_out, key_hi, key_lo}, {1'b0, m});
    end
    run_en = 1'b0;
    // idle: hit planted on current key must not matter
    target = m; match_en = 1'b1;
    tick(5);
    chk("R8 idle hold with hit", {ser_out, key_hi, key_lo}, {1'b0, m});
    match_en = 1'b0;
  endtask

  task automatic t_hit();
    logic [63:0] m;
    logic [64:0] got;
    m = 64'h1;
    for (int i = 0; i < 300; i++) m = model_next(m);
    do_reset();
    target = m; match_en = 1'b1; run_en = 1'b1;
    tick(400);
    chk("R6 planted key found", {ser_out, key_hi, key_lo}, {1'b1, m});
    tick(10);
    chk("R7 held under hit", {ser_out, key_hi, key_lo}, {1'b1, m});
    match_en = 1'b0;
    tick(10);
    chk("R7 held after hit drops", {ser_out, key_hi, key_lo}, {1'b1, m});
    run_en = 1'b0;
    read_word(got);
    chk("R3 readout of found key", got, {1'b1, m});
  endtask

  task automatic t_zero_hit();
    do_reset();
    target = 64'h0; match_en = 1'b1; run_en = 1'b1;
    tick(3);
    chk("R6 zero key matched", {ser_out, key_hi, key_lo}, {1'b1, 64'h0});
    run_en = 1'b0; match_en = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(1);
    t_reset();
    t_roundtrip();
    t_steps();
    t_hit();
    t_zero_hit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule